// File: doc/BRIEF.md
# Table-Access Program Memory Port

This block connects a 16-bit data-side access port to a program memory whose words are 24 bits wide. A request supplies an 8-bit page value and a 16-bit effective address, selects the low or the high half-space, and chooses word or byte width. The 24-bit word appears as two 16-bit spaces that share one address range. The low space holds word bits [15:0]. The high space holds bits [23:16] in its lower byte. Its upper byte does not exist: it reads as zero, and writes to it are discarded.

Reads of ordinary addresses go to an external memory through a strobe and a 24-bit address. The word comes back one cycle later, and the block selects the requested lane from it. Writes never reach the memory. They load a small bank of holding latches that sit in a fixed address window on page 0xFA. Loading N program words takes N low-space writes and N high-space writes. Reads that fall inside the window return latch contents instead of memory data. The latches are set to all ones at reset and whenever a program operation finishes.

Top module: `prog_table_port`

## Requirements
- R1: For a read outside the latch window, `mem_rd_o` is high in the request cycle and `mem_addr_o` equals {`page_i`, `ea_i`}.
- R2: `rd_valid_o` is high exactly in the cycle after a cycle with `rd_en_i` high. `rd_data_o` is zero whenever `rd_valid_o` is low, including during reset.
- R3: A low-space word read (`hi_space_i`=0, `byte_mode_i`=0) returns word bits [15:0]. Address bit 0 has no effect on it.
- R4: A low-space byte read returns bits [7:0] when `ea_i[0]`=0 and bits [15:8] when `ea_i[0]`=1, placed in `rd_data_o[7:0]`, with `rd_data_o[15:8]`=0.
- R5: A high-space word read, or a high-space byte read with `ea_i[0]`=0, returns {8'h00, bits [23:16]}. A high-space byte read with `ea_i[0]`=1 addresses the phantom byte and returns 16'h0000.
- R6: A write changes latch k only when `page_i`=0xFA and `ea_i[15:1]`=k. A write to any other page changes no latch.
- R7: A low-space word write stores all 16 data bits into [15:0]. A high-space word write stores `wr_data_i[7:0]` into [23:16]. A byte write stores `wr_data_i[7:0]` into the lane chosen as in R4/R5. `wr_data_i[15:8]` is ignored by high-space writes and by byte writes.
- R8: A high-space byte write with `ea_i[0]`=1 targets the phantom byte and changes no latch.
- R9: On page 0xFA, writes with `ea_i[15:1]` >= LATCH_WORDS are dropped. Reads at such addresses go to the memory.
- R10: A read with `page_i`=0xFA and `ea_i[15:1]` < LATCH_WORDS returns the addressed latch word through the lane rules of R3 to R5, and does not raise `mem_rd_o`.
- R11: All latches hold 24'hFFFFFF after reset and after a cycle with `prog_done_i` high. A write in that same cycle is lost.
- R12: N low-space word writes plus N high-space word writes to consecutive latch addresses load N complete 24-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_i | input | 8 | Page value, upper address byte |
| ea_i | input | 16 | Effective address; bit 0 selects the byte in byte mode |
| hi_space_i | input | 1 | 1 selects the high half-space |
| byte_mode_i | input | 1 | 1 selects byte width |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (latches only) |
| wr_data_i | input | 16 | Write data |
| prog_done_i | input | 1 | Program operation finished; presets the latches |
| mem_addr_o | output | 24 | Program memory address |
| mem_rd_o | output | 1 | Program memory read strobe |
| mem_rdata_i | input | 24 | Program memory word, valid one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |

## Verification
The bench builds the block with LATCH_WORDS set to 2, the double-word latch layout. With that setting the end of the window (0xFA0002) and the first address past it (0xFA0004) lie only a few vectors apart. The dropped write at 0xFA0004 would also alias latch 0 under a faulty range check, so a bad check shows up as a changed read-back. The default of 128 latches is covered only by elaboration. At that size every latch index can be reached from the effective address, so the out-of-range path is exercised in the bench only through the 2-latch build.

// File: rtl/prog_table_pkg.sv
`timescale 1ns/1ps
package prog_table_pkg;
  localparam int PWORD_W = 24;
  localparam int DATA_W  = 16;
  localparam int PAGE_W  = 8;
  localparam int EA_W    = 16;

  typedef logic [PWORD_W-1:0] pword_t;

  typedef struct packed {
    logic hi;
    logic byte_md;
    logic b0;
  } lane_t;

  function automatic logic [PAGE_W+EA_W-1:0] form_addr(logic [PAGE_W-1:0] pg,
                                                      logic [EA_W-1:0] ea);
    return {pg, ea};
  endfunction

  // Pick the requested lane out of a 24-bit word; the phantom byte reads as zero.
  function automatic logic [DATA_W-1:0] lane_extract(pword_t w, lane_t l);
    logic [7:0] b;
    if (!l.byte_md) begin
      if (l.hi) return {8'h00, w[23:16]};
      return w[15:0];
    end
    if (l.hi) b = l.b0 ? 8'h00 : w[23:16];
    else      b = l.b0 ? w[15:8] : w[7:0];
    return {8'h00, b};
  endfunction

  // Merge write data into a latch word; phantom-byte writes leave it untouched.
  function automatic pword_t lane_merge(pword_t w, logic [DATA_W-1:0] d, lane_t l);
    pword_t r;
    r = w;
    if (!l.byte_md) begin
      if (l.hi) r[23:16] = d[7:0];
      else      r[15:0]  = d;
    end else if (l.hi) begin
      if (!l.b0) r[23:16] = d[7:0];
    end else if (l.b0) begin
      r[15:8] = d[7:0];
    end else begin
      r[7:0] = d[7:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/prog_table_decode.sv
`timescale 1ns/1ps
module prog_table_decode
  import prog_table_pkg::*;
#(
  parameter int LATCH_WORDS = 128,
  parameter logic [7:0] LATCH_PAGE = 8'hFA,
  parameter int IDX_W = 7
) (
  input  logic [PAGE_W-1:0]      page,
  input  logic [EA_W-1:0]        ea,
  output logic [PAGE_W+EA_W-1:0] full_addr,
  output logic                   latch_hit,
  output logic [IDX_W-1:0]       latch_idx
);
  assign full_addr = form_addr(page, ea);
  assign latch_hit = (page == LATCH_PAGE) && (ea[EA_W-1:1] < (EA_W-1)'(LATCH_WORDS));
  assign latch_idx = ea[IDX_W:1];
endmodule

// File: rtl/prog_table_latches.sv
`timescale 1ns/1ps
module prog_table_latches
  import prog_table_pkg::*;
#(
  parameter int LATCH_WORDS = 128,
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  input  lane_t             lane,
  output pword_t            rd_word
);
  pword_t lat [LATCH_WORDS];

  for (genvar i = 0; i < LATCH_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              lat[i] <= '1;
      else if (preset)                         lat[i] <= '1;
      else if (wr_fire && idx == IDX_W'(i))    lat[i] <= lane_merge(lat[i], wr_data, lane);
    end
  end

  assign rd_word = lat[idx];
endmodule

// File: rtl/prog_table_read_path.sv
`timescale 1ns/1ps
module prog_table_read_path
  import prog_table_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  lane_t             lane,
  input  logic              from_latch,
  input  pword_t            latch_word,
  input  pword_t            mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic   valid_q;
  lane_t  lane_q;
  logic   from_latch_q;
  pword_t latch_word_q;
  pword_t src_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= 1'b0;
      lane_q       <= '0;
      from_latch_q <= 1'b0;
      latch_word_q <= '0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) begin
        lane_q       <= lane;
        from_latch_q <= from_latch;
        latch_word_q <= latch_word;
      end
    end
  end

  assign src_word = from_latch_q ? latch_word_q : mem_rdata;
  assign rd_valid = valid_q;
  assign rd_data  = valid_q ? lane_extract(src_word, lane_q) : '0;
endmodule

// File: rtl/prog_table_port.sv
`timescale 1ns/1ps
module prog_table_port
  import prog_table_pkg::*;
#(
  parameter int LATCH_WORDS = 128,
  parameter logic [7:0] LATCH_PAGE = 8'hFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  page_i,
  input  logic [15:0] ea_i,
  input  logic        hi_space_i,
  input  logic        byte_mode_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        prog_done_i,
  output logic [23:0] mem_addr_o,
  output logic        mem_rd_o,
  input  logic [23:0] mem_rdata_i,
  output logic        rd_valid_o,
  output logic [15:0] rd_data_o
);
  localparam int IDX_W = (LATCH_WORDS > 2) ? $clog2(LATCH_WORDS) : 1;

  // Named internal events
  logic             latch_hit;
  logic [IDX_W-1:0] latch_idx;
  logic             latch_wr_fire;
  logic             latch_preset;
  lane_t            lane;
  pword_t           latch_word;

  assign lane          = '{hi: hi_space_i, byte_md: byte_mode_i, b0: ea_i[0]};
  assign latch_wr_fire = wr_en_i & latch_hit;
  assign latch_preset  = prog_done_i;
  assign mem_rd_o      = rd_en_i & ~latch_hit;

  prog_table_decode #(
    .LATCH_WORDS(LATCH_WORDS), .LATCH_PAGE(LATCH_PAGE), .IDX_W(IDX_W)
  ) u_decode (
    .page(page_i), .ea(ea_i), .full_addr(mem_addr_o),
    .latch_hit(latch_hit), .latch_idx(latch_idx)
  );

  prog_table_latches #(.LATCH_WORDS(LATCH_WORDS), .IDX_W(IDX_W)) u_latches (
    .clk(clk), .rst_n(rst_n), .preset(latch_preset), .wr_fire(latch_wr_fire),
    .idx(latch_idx), .wr_data(wr_data_i), .lane(lane), .rd_word(latch_word)
  );

  prog_table_read_path u_read (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i), .lane(lane),
    .from_latch(latch_hit), .latch_word(latch_word), .mem_rdata(mem_rdata_i),
    .rd_valid(rd_valid_o), .rd_data(rd_data_o)
  );
endmodule

// File: rtl/prog_table_port_chk.sv
`timescale 1ns/1ps
module prog_table_port_chk #(
  parameter int LATCH_WORDS = 128,
  parameter logic [7:0] LATCH_PAGE = 8'hFA
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  page_i,
  input logic [15:0] ea_i,
  input logic        hi_space_i,
  input logic        byte_mode_i,
  input logic        rd_en_i,
  input logic        mem_rd_o,
  input logic        rd_valid_o,
  input logic [15:0] rd_data_o
);
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);  // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);  // R2
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> rd_data_o == 16'h0000);  // R2
  AST_MEM_STROBE_OFF_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && page_i != LATCH_PAGE |-> mem_rd_o);  // R1
  AST_LATCH_READ_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && page_i == LATCH_PAGE && ea_i[15:1] < 15'(LATCH_WORDS) |-> !mem_rd_o);  // R10
  AST_PHANTOM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && $past(hi_space_i && byte_mode_i && ea_i[0]) |-> rd_data_o == 16'h0000);  // R5
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && $past(hi_space_i || byte_mode_i) |-> rd_data_o[15:8] == 8'h00);  // R4
endmodule

bind prog_table_port prog_table_port_chk #(
  .LATCH_WORDS(LATCH_WORDS), .LATCH_PAGE(LATCH_PAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .page_i(page_i), .ea_i(ea_i),
  .hi_space_i(hi_space_i), .byte_mode_i(byte_mode_i), .rd_en_i(rd_en_i),
  .mem_rd_o(mem_rd_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
);

// File: tb/prog_table_port_test.sv
`timescale 1ns/1ps
module prog_table_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  page_i = '0;
  logic [15:0] ea_i = '0;
  logic        hi_space_i = 1'b0;
  logic        byte_mode_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        prog_done_i = 1'b0;
  logic [23:0] mem_addr_o;
  logic        mem_rd_o;
  logic [23:0] mem_rdata_i = '0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  prog_table_port #(.LATCH_WORDS(2), .LATCH_PAGE(8'hFA)) uut (.*);

  // Behavioural program memory, one-cycle read latency
  function automatic logic [23:0] mem_model(logic [23:0] a);
    logic [22:0] w;
    w = a[23:1];
    return {w[7:0] + 8'h11, w[15:8] ^ 8'hA5, w[7:0] ^ 8'h5A};
  endfunction

  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem_model(mem_addr_o);

  function automatic logic [15:0] pick(logic [23:0] w, logic hi, logic bm, logic b0);
    case ({hi, bm, b0})
      3'b000, 3'b001: return w[15:0];
      3'b010:         return {8'h00, w[7:0]};
      3'b011:         return {8'h00, w[15:8]};
      3'b100, 3'b101,
      3'b110:         return {8'h00, w[23:16]};
      default:        return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] pg, input logic [15:0] ea, input logic hi,
                          input logic bm, input logic [15:0] d, input logic pd);
    @(negedge clk);
    page_i = pg; ea_i = ea; hi_space_i = hi; byte_mode_i = bm;
    wr_data_i = d; wr_en_i = 1'b1; prog_done_i = pd;
    @(negedge clk);
    wr_en_i = 1'b0; prog_done_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] pg, input logic [15:0] ea, input logic hi,
                         input logic bm, output logic mrd, output logic [23:0] maddr,
                         output logic v, output logic [15:0] d);
    @(negedge clk);
    page_i = pg; ea_i = ea; hi_space_i = hi; byte_mode_i = bm; rd_en_i = 1'b1;
    #1;
    mrd = mem_rd_o; maddr = mem_addr_o;
    @(negedge clk);
    rd_en_i = 1'b0;
    v = rd_valid_o; d = rd_data_o;
  endtask

  typedef struct packed {
    logic [23:0] tag;
    logic        wr;
    logic [7:0]  pg;
    logic [15:0] ea;
    logic        hi;
    logic        bm;
    logic [15:0] dat;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{"R11", 1'b0, 8'hFA, 16'h0000, 1'b0, 1'b0, 16'hFFFF},
    '{"R11", 1'b0, 8'hFA, 16'h0000, 1'b1, 1'b0, 16'h00FF},
    '{"R7 ", 1'b1, 8'hFA, 16'h0000, 1'b0, 1'b0, 16'h1234},
    '{"R7 ", 1'b1, 8'hFA, 16'h0000, 1'b1, 1'b0, 16'hAB56},
    '{"R3 ", 1'b0, 8'hFA, 16'h0001, 1'b0, 1'b0, 16'h1234},
    '{"R7 ", 1'b0, 8'hFA, 16'h0000, 1'b1, 1'b0, 16'h0056},
    '{"R7 ", 1'b1, 8'hFA, 16'h0002, 1'b0, 1'b1, 16'hEE78},
    '{"R7 ", 1'b1, 8'hFA, 16'h0003, 1'b0, 1'b1, 16'hDD9A},
    '{"R7 ", 1'b1, 8'hFA, 16'h0002, 1'b1, 1'b1, 16'hCCBC},
    '{"R8 ", 1'b1, 8'hFA, 16'h0003, 1'b1, 1'b1, 16'h0011},
    '{"R8 ", 1'b0, 8'hFA, 16'h0002, 1'b1, 1'b0, 16'h00BC},
    '{"R10", 1'b0, 8'hFA, 16'h0002, 1'b0, 1'b0, 16'h9A78},
    '{"R4 ", 1'b0, 8'hFA, 16'h0003, 1'b0, 1'b1, 16'h009A},
    '{"R4 ", 1'b0, 8'hFA, 16'h0002, 1'b0, 1'b1, 16'h0078},
    '{"R5 ", 1'b0, 8'hFA, 16'h0003, 1'b1, 1'b1, 16'h0000},
    '{"R5 ", 1'b0, 8'hFA, 16'h0002, 1'b1, 1'b1, 16'h00BC},
    '{"R9 ", 1'b1, 8'hFA, 16'h0004, 1'b0, 1'b0, 16'h4444},
    '{"R9 ", 1'b0, 8'hFA, 16'h0000, 1'b0, 1'b0, 16'h1234},
    '{"R6 ", 1'b1, 8'hF9, 16'h0000, 1'b0, 1'b0, 16'h7777},
    '{"R6 ", 1'b0, 8'hFA, 16'h0000, 1'b0, 1'b0, 16'h1234}
  };

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic        mrd, v;
    logic [23:0] maddr;
    logic [15:0] d;

    // Reset state
    repeat (3) @(negedge clk);
    chk("R2", "rd_valid in reset", 32'(rd_valid_o), 32'd0);
    chk("R2", "rd_data in reset", 32'(rd_data_o), 32'd0);
    chk("R1", "mem_rd in reset", 32'(mem_rd_o), 32'd0);
    rst_n = 1'b1;

    // Latch window vectors
    for (int i = 0; i < NV; i++) begin
      vec_t  e;
      string t;
      e = VECS[i];
      t = $sformatf("%s", e.tag);
      if (e.wr) begin
        do_write(e.pg, e.ea, e.hi, e.bm, e.dat, 1'b0);
      end else begin
        do_read(e.pg, e.ea, e.hi, e.bm, mrd, maddr, v, d);
        chk(t, "latch read data", 32'(d), 32'(e.dat));
        chk("R10", "no memory strobe on latch read", 32'(mrd), 32'd0);
        chk("R2", "valid on latch read", 32'(v), 32'd1);
      end
    end

    // Memory reads across lanes
    begin
      logic [7:0]  pgs [6] = '{8'h12, 8'h12, 8'h12, 8'h7E, 8'h7E, 8'hFA};
      logic [15:0] eas [6] = '{16'h3456, 16'h3457, 16'h3457, 16'hFFFF, 16'hFFFE, 16'h0004};
      logic        his [6] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
      logic        bms [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      for (int k = 0; k < 6; k++) begin
        logic [15:0] exp;
        exp = pick(mem_model({pgs[k], eas[k]}), his[k], bms[k], eas[k][0]);
        do_read(pgs[k], eas[k], his[k], bms[k], mrd, maddr, v, d);
        chk("R1", "mem strobe", 32'(mrd), 32'd1);
        chk("R1", "mem address", 32'(maddr), 32'({pgs[k], eas[k]}));
        chk("R2", "valid next cycle", 32'(v), 32'd1);
        chk(k == 5 ? "R9" : (his[k] ? "R5" : (bms[k] ? "R4" : "R3")), "mem read data",
            32'(d), 32'(exp));
      end
      @(negedge clk);
      chk("R2", "valid drops after read", 32'(rd_valid_o), 32'd0);
      chk("R2", "data zero when idle", 32'(rd_data_o), 32'd0);
    end

    // R12: two full words via low and high writes
    do_write(8'hFA, 16'h0000, 1'b0, 1'b0, 16'hA1B2, 1'b0);
    do_write(8'hFA, 16'h0002, 1'b0, 1'b0, 16'hD4E5, 1'b0);
    do_write(8'hFA, 16'h0000, 1'b1, 1'b0, 16'h00C3, 1'b0);
    do_write(8'hFA, 16'h0002, 1'b1, 1'b0, 16'h00F6, 1'b0);
    do_read(8'hFA, 16'h0000, 1'b0, 1'b0, mrd, maddr, v, d);
    chk("R12", "word0 low", 32'(d), 32'h0000A1B2);
    do_read(8'hFA, 16'h0000, 1'b1, 1'b0, mrd, maddr, v, d);
    chk("R12", "word0 high", 32'(d), 32'h000000C3);
    do_read(8'hFA, 16'h0002, 1'b0, 1'b0, mrd, maddr, v, d);
    chk("R12", "word1 low", 32'(d), 32'h0000D4E5);
    do_read(8'hFA, 16'h0002, 1'b1, 1'b0, mrd, maddr, v, d);
    chk("R12", "word1 high", 32'(d), 32'h000000F6);

    // R11: preset on program completion beats a simultaneous write
    do_write(8'hFA, 16'h0000, 1'b0, 1'b0, 16'h1357, 1'b1);
    do_read(8'hFA, 16'h0000, 1'b0, 1'b0, mrd, maddr, v, d);
    chk("R11", "preset wins over write", 32'(d), 32'h0000FFFF);
    do_read(8'hFA, 16'h0002, 1'b1, 1'b0, mrd, maddr, v, d);
    chk("R11", "preset clears word1", 32'(d), 32'h000000FF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule